// File: doc/BRIEF.md
# Interrupt Controller Indirect Register File

This block is the register front end of an I/O interrupt controller with 24 input pins. A 32-bit bus slave exposes two locations. One is an 8-bit select register. The other is a data window. The select value chooses what the window reaches: the controller identification, the version word, the arbitration word, or one 32-bit half of a 64-bit redirection entry. There is one redirection entry per pin. Each entry holds a vector, delivery mode, destination mode, polarity, trigger mode, mask and destination ID. Each entry also holds two status bits, delivery status and remote-IRR, which the delivery logic owns.

Requests arrive on a valid/ready channel. Every accepted request returns exactly one response beat on a second valid/ready channel. The response holds read data, or zero for a write. The response register holds a single beat, so the slave accepts a new request only while that register is empty or is being drained in the same cycle. A response that the consumer does not take stays on the bus without change.

Toward the delivery logic, the block presents every entry as a flat vector. It emits a one-cycle rewrite strobe per pin and a one-cycle mask-change event that carries the pin number and the new mask value. Three per-pin inputs feed the status bits: remote-IRR set, remote-IRR clear, and a busy level that is copied into delivery status.

Top module: `irq_regfile`

## Requirements
- R1: A write at offset 0x00 stores data bits 7:0 in the select register and discards the upper bits. A read at offset 0x00 returns the select value zero-extended.
- R2: With select 0x01, the window reads {8'h00, pin count minus one, 8'h00, version code}, where the version code defaults to 8'h11 (24 pins give 32'h0017_0011). A write with select 0x01 changes nothing.
- R3: With select 0x00 or 0x02, the window reads the 4-bit ID in bits 27:24 and zero in all other bits. A write with select 0x00 loads the ID from data bits 27:24. A write with select 0x02 changes nothing.
- R4: A select of 0x10 or higher addresses entry (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. A write replaces only that half.
- R5: If the computed entry number is 24 or more, a window read returns 32'hFFFF_FFFF and a window write changes no entry and raises no strobe.
- R6: The entry layout is vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger 15 (1 = level), mask 16 and destination ID 63:56. Bus writes never change bits 12 and 14.
- R7: After any entry write that leaves the trigger bit at 0 (edge), that entry's remote-IRR bit is 0.
- R8: A write to an entry's lower half that changes its mask bit raises mask_chg_valid for one cycle in the cycle after acceptance. The pulse carries the pin number and the new mask value.
- R9: Reset sets every entry to 64'h0000_0000_0001_0000 (masked, all else 0). Reset also clears the select register and the ID to 0.
- R10: An access at any offset other than 0x00 and 0x10 reads zero and has no effect when written. A window read with select 0x03 to 0x0F returns zero.
- R11: A request is accepted when req_valid is high and req_ready is high. req_ready is high when no response is held or when the held response is being taken. The response appears in the cycle after acceptance (rdata is 0 for writes) and holds steady while rsp_ready is low.
- R12: Each accepted in-range entry write raises entry_wr[pin] for exactly one cycle, the cycle after acceptance. At most one strobe bit is high at a time.
- R13: rirr_set[p] sets and rirr_clr[p] clears remote-IRR of pin p at the next edge, and clear wins over set. A write-induced edge clear (R7) wins over both. Delivery status copies dlv_busy[p] with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rirr_set | input | 24 | Per-pin remote-IRR set |
| rirr_clr | input | 24 | Per-pin remote-IRR clear |
| dlv_busy | input | 24 | Per-pin delivery-status source |
| ent_flat | output | 1536 | All entries, pin p at bits 64p+63:64p |
| entry_wr | output | 24 | One-cycle per-pin rewrite strobe |
| mask_chg_valid | output | 1 | One-cycle mask-change event |
| mask_chg_pin | output | 5 | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |

## Verification
Every result of an accepted request is due exactly one cycle after the accepting edge: the response beat, the entry contents on ent_flat, the rewrite strobe and the mask event. Status-input effects are due one cycle after the edge that samples them. The bench keeps a behavioural model that advances on the same rising edge from the same inputs. It compares every output on the falling edge, so each check lands in the first cycle a result is due and never a cycle early. Directed reads are checked on the falling edge just after acceptance. The back-pressure case holds rsp_ready low for several cycles and compares each of those cycles.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;
  localparam int ENT_W    = 64;
  localparam int BIT_DSTS = 12;
  localparam int BIT_RIRR = 14;
  localparam int BIT_TRIG = 15;
  localparam int BIT_MASK = 16;
  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL  = 8'h10;
  localparam logic [31:0] RESET_LO = 32'h0001_0000;

  function automatic logic [31:0] version_word(input int npins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction
endpackage

// File: rtl/irq_rf_entry.sv
module irq_rf_entry
  import irq_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  input  logic        busy_in,
  output logic [ENT_W-1:0] ent,
  output logic        mask_flip
);
  logic [31:0] lo_q, hi_q;
  logic        rirr_q, dsts_q;
  logic        trig_after, rirr_nxt;

  assign trig_after = (wr_en && !wr_hi) ? wdata[BIT_TRIG] : lo_q[BIT_TRIG];
  assign mask_flip  = wr_en && !wr_hi && (wdata[BIT_MASK] != lo_q[BIT_MASK]);

  always_comb begin
    if (wr_en && !trig_after)  rirr_nxt = 1'b0;
    else if (rirr_clr)         rirr_nxt = 1'b0;
    else if (rirr_set)         rirr_nxt = 1'b1;
    else                       rirr_nxt = rirr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= RESET_LO;
      hi_q   <= '0;
      rirr_q <= 1'b0;
      dsts_q <= 1'b0;
    end else begin
      dsts_q <= busy_in;
      rirr_q <= rirr_nxt;
      if (wr_en) begin
        if (wr_hi) hi_q <= wdata;
        else       lo_q <= wdata;
      end
    end
  end

  assign ent = {hi_q, lo_q[31:BIT_RIRR+1], rirr_q, lo_q[BIT_DSTS+1],
                dsts_q, lo_q[BIT_DSTS-1:0]};
endmodule

// File: rtl/irq_rf_rdmux.sv
module irq_rf_rdmux
  import irq_rf_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [7:0] VER_CODE = 8'h11
)(
  input  logic [7:0]             sel,
  input  logic [3:0]             id,
  input  logic [NPINS*ENT_W-1:0] ent_flat,
  output logic [31:0]            rdata
);
  logic [6:0]       idx;
  logic             in_tbl;
  logic [ENT_W-1:0] ent_sel;

  assign idx    = 7'((sel - SEL_TBL) >> 1);
  assign in_tbl = (sel >= SEL_TBL);

  always_comb begin
    ent_sel = '1;
    for (int p = 0; p < NPINS; p++)
      if (idx == 7'(p)) ent_sel = ent_flat[p*ENT_W +: ENT_W];
  end

  always_comb begin
    if (in_tbl)                              rdata = sel[0] ? ent_sel[63:32] : ent_sel[31:0];
    else if (sel == SEL_VER)                 rdata = version_word(NPINS, VER_CODE);
    else if (sel == SEL_ID || sel == SEL_ARB) rdata = {4'h0, id, 24'h0};
    else                                     rdata = '0;
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_rf_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int AW = 8,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int PW = $clog2(NPINS)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_rdata,
  input  logic [NPINS-1:0]       rirr_set,
  input  logic [NPINS-1:0]       rirr_clr,
  input  logic [NPINS-1:0]       dlv_busy,
  output logic [NPINS*ENT_W-1:0] ent_flat,
  output logic [NPINS-1:0]       entry_wr,
  output logic                   mask_chg_valid,
  output logic [PW-1:0]          mask_chg_pin,
  output logic                   mask_chg_val
);
  localparam logic [AW-1:0] OFF_SEL = AW'(8'h00);
  localparam logic [AW-1:0] OFF_WIN = AW'(8'h10);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic             accept, hit_sel, hit_win;
  logic [31:0]      win_rdata, rd_next;
  logic [6:0]       win_idx;
  logic             win_in_range;
  logic [NPINS-1:0] wr_vec, flip_vec;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign hit_sel   = (req_addr == OFF_SEL);
  assign hit_win   = (req_addr == OFF_WIN);

  assign win_idx      = 7'((sel_q - SEL_TBL) >> 1);
  assign win_in_range = (sel_q >= SEL_TBL) && (win_idx < 7'(NPINS));

  irq_rf_rdmux #(.NPINS(NPINS), .VER_CODE(VER_CODE)) u_rdmux (
    .sel(sel_q), .id(id_q), .ent_flat(ent_flat), .rdata(win_rdata)
  );

  always_comb begin
    if (req_write)    rd_next = '0;
    else if (hit_sel) rd_next = {24'h0, sel_q};
    else if (hit_win) rd_next = win_rdata;
    else              rd_next = '0;
  end

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      assign wr_vec[g] = accept && req_write && hit_win && win_in_range &&
                         (win_idx == 7'(g));
      irq_rf_entry u_ent (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_vec[g]), .wr_hi(sel_q[0]), .wdata(req_wdata),
        .rirr_set(rirr_set[g]), .rirr_clr(rirr_clr[g]), .busy_in(dlv_busy[g]),
        .ent(ent_flat[g*ENT_W +: ENT_W]), .mask_flip(flip_vec[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q          <= '0;
      id_q           <= '0;
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      entry_wr       <= '0;
      mask_chg_valid <= 1'b0;
      mask_chg_pin   <= '0;
      mask_chg_val   <= 1'b0;
    end else begin
      entry_wr       <= wr_vec;
      mask_chg_valid <= |flip_vec;
      mask_chg_pin   <= win_idx[PW-1:0];
      mask_chg_val   <= req_wdata[BIT_MASK];
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_next;
        if (req_write && hit_sel) sel_q <= req_wdata[7:0];
        if (req_write && hit_win && sel_q == SEL_ID) id_q <= req_wdata[27:24];
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_regfile_chk.sv
module irq_regfile_chk #(
  parameter int NPINS = 24,
  parameter int PW = 5
)(
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic [NPINS*64-1:0] ent_flat,
  input logic [NPINS-1:0]    entry_wr,
  input logic                mask_chg_valid,
  input logic [PW-1:0]       mask_chg_pin,
  input logic                mask_chg_val
);
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_wr_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_wr));

  p_mask_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_valid |-> entry_wr[mask_chg_pin]);

  p_mask_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_valid |-> ent_flat[int'(mask_chg_pin)*64 + 16] == mask_chg_val);

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_chk
      p_edge_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_wr[g] && !ent_flat[g*64+15] |-> !ent_flat[g*64+14]);
    end
  endgenerate
endmodule

bind irq_regfile irq_regfile_chk #(.NPINS(NPINS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .ent_flat(ent_flat), .entry_wr(entry_wr), .mask_chg_valid(mask_chg_valid),
  .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val)
);

// File: tb/irq_regfile_bench.sv
module irq_regfile_bench;
  localparam int N = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [N-1:0] rirr_set = 0, rirr_clr = 0, dlv_busy = 0;
  logic req_ready, rsp_valid, mask_chg_valid, mask_chg_val;
  logic [31:0] rsp_rdata;
  logic [N*64-1:0] ent_flat;
  logic [N-1:0] entry_wr;
  logic [4:0] mask_chg_pin;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_regfile u_irq_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rirr_set(rirr_set), .rirr_clr(rirr_clr), .dlv_busy(dlv_busy),
    .ent_flat(ent_flat), .entry_wr(entry_wr), .mask_chg_valid(mask_chg_valid),
    .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val)
  );

  // behavioural reference model
  logic [63:0] m_ent [N];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic        m_rv;
  logic [31:0] m_rd;
  logic [N-1:0] m_wr;
  logic        m_mv, m_mval;
  int          m_mpin;

  function automatic logic [31:0] m_window();
    int e;
    if (m_sel >= 8'h10) begin
      e = (int'(m_sel) - 16) / 2;
      if (e >= N) return 32'hFFFF_FFFF;
      return m_sel[0] ? m_ent[e][63:32] : m_ent[e][31:0];
    end
    if (m_sel == 8'h01) return 32'h0017_0011;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) m_ent[p] = 64'h0000_0000_0001_0000;
      m_sel = 0; m_id = 0; m_rv = 0; m_rd = 0; m_wr = 0; m_mv = 0; m_mval = 0; m_mpin = 0;
    end else begin
      bit acc;
      int we;
      logic [63:0] old, nw;
      acc = req_valid && (!m_rv || rsp_ready);
      m_wr = 0; m_mv = 0; we = -1;
      if (acc) begin
        m_rv = 1;
        if (req_write) m_rd = 0;
        else if (req_addr == 8'h00) m_rd = {24'h0, m_sel};
        else if (req_addr == 8'h10) m_rd = m_window();
        else m_rd = 0;
        if (req_write && req_addr == 8'h10) begin
          if (m_sel == 8'h00) m_id = req_wdata[27:24];
          if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < N) begin
            we = (int'(m_sel) - 16) / 2;
            old = m_ent[we];
            nw = old;
            if (m_sel[0]) nw[63:32] = req_wdata; else nw[31:0] = req_wdata;
            nw[12] = old[12]; nw[14] = old[14];
            if (!nw[15]) nw[14] = 0;
            m_ent[we] = nw;
            m_wr[we] = 1;
            if (nw[16] != old[16]) begin m_mv = 1; m_mpin = we; m_mval = nw[16]; end
          end
        end
        if (req_write && req_addr == 8'h00) m_sel = req_wdata[7:0];
      end else if (rsp_ready) m_rv = 0;
      for (int p = 0; p < N; p++) begin
        m_ent[p][12] = dlv_busy[p];
        if (!(p == we && !m_ent[p][15])) begin
          if (rirr_clr[p]) m_ent[p][14] = 0;
          else if (rirr_set[p]) m_ent[p][14] = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(req_ready == (!m_rv || rsp_ready), "R11 req_ready", 64'(req_ready), 64'(!m_rv || rsp_ready));
    chk(rsp_valid == m_rv, "R11 rsp_valid", 64'(rsp_valid), 64'(m_rv));
    if (m_rv) chk(rsp_rdata == m_rd, "R11 rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
    chk(entry_wr == m_wr, "R12 entry_wr", 64'(entry_wr), 64'(m_wr));
    chk(mask_chg_valid == m_mv, "R8 mask valid", 64'(mask_chg_valid), 64'(m_mv));
    if (m_mv) chk({mask_chg_pin, mask_chg_val} == {5'(m_mpin), m_mval}, "R8 mask pin/val",
                  64'({mask_chg_pin, mask_chg_val}), 64'({5'(m_mpin), m_mval}));
    for (int p = 0; p < N; p++)
      if (ent_flat[p*64 +: 64] !== m_ent[p])
        chk(0, "R6 entry content", ent_flat[p*64 +: 64], m_ent[p]);
  end

  task automatic send(input bit wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    send(0, a, 0);
    chk(rsp_valid && rsp_rdata == exp, tag, 64'(rsp_rdata), 64'(exp));
  endtask

  task automatic wsel(input logic [7:0] s); send(1, 8'h00, {24'hABCDEF, s}); endtask

  initial begin
    #200_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9 reset state
    chk(ent_flat[63:0] == 64'h0000_0000_0001_0000, "R9 reset entry0", ent_flat[63:0], 64'h10000);
    chk(ent_flat[23*64 +: 64] == 64'h0000_0000_0001_0000, "R9 reset entry23", ent_flat[23*64 +: 64], 64'h10000);
    rd(8'h00, 32'h0, "R9 select after reset");
    rd(8'h10, 32'h0, "R9 id after reset");
    // R1 select storage
    send(1, 8'h00, 32'hABCD_0110);
    rd(8'h00, 32'h10, "R1 select readback");
    rd(8'h10, 32'h0001_0000, "R9 entry0 low masked");
    wsel(8'h11); rd(8'h10, 32'h0, "R9 entry0 high");
    // R2 version
    wsel(8'h01); rd(8'h10, 32'h0017_0011, "R2 version");
    send(1, 8'h10, 32'hFFFF_FFFF); rd(8'h10, 32'h0017_0011, "R2 version write ignored");
    // R3 identification / arbitration
    wsel(8'h00); send(1, 8'h10, 32'h5A00_0000); rd(8'h10, 32'h0A00_0000, "R3 id load");
    wsel(8'h02); rd(8'h10, 32'h0A00_0000, "R3 arb read");
    send(1, 8'h10, 32'h0300_0000); wsel(8'h00); rd(8'h10, 32'h0A00_0000, "R3 arb write ignored");
    // R4/R6/R8 entry 5
    wsel(8'h1A); send(1, 8'h10, 32'h0000_58A5);
    rd(8'h10, 32'h0000_08A5, "R6 status bits kept on write");
    wsel(8'h1B); send(1, 8'h10, 32'hC300_0000); rd(8'h10, 32'hC300_0000, "R4 upper half");
    wsel(8'h1A); rd(8'h10, 32'h0000_08A5, "R4 lower half untouched");
    // R13 status inputs
    send(1, 8'h10, 32'h0000_88A5);
    @(negedge clk); rirr_set[5] = 1; dlv_busy[5] = 1;
    @(negedge clk); rirr_set[5] = 0;
    rd(8'h10, 32'h0000_D8A5, "R13 rirr set and busy");
    wsel(8'h1B); send(1, 8'h10, 32'h1100_0000);
    wsel(8'h1A); rd(8'h10, 32'h0000_D8A5, "R6 rirr kept on high write");
    // R7 edge clears remote-IRR, R8 mask set
    send(1, 8'h10, 32'h0001_08A5); rd(8'h10, 32'h0001_18A5, "R7 edge write clears rirr");
    @(negedge clk); dlv_busy[5] = 0;
    @(negedge clk); rd(8'h10, 32'h0001_08A5, "R13 busy drop");
    // R7 in edge mode, upper half write clears rirr set while edge
    @(negedge clk); rirr_set[5] = 1; @(negedge clk); rirr_set[5] = 0;
    rd(8'h10, 32'h0001_48A5, "R13 rirr set in edge mode");
    wsel(8'h1B); send(1, 8'h10, 32'h2200_0000);
    wsel(8'h1A); rd(8'h10, 32'h0001_08A5, "R7 high write in edge mode clears rirr");
    // R13 clear beats set
    send(1, 8'h10, 32'h0000_80A5);
    @(negedge clk); rirr_set[5] = 1; rirr_clr[5] = 1;
    @(negedge clk); rirr_set[5] = 0; rirr_clr[5] = 0;
    rd(8'h10, 32'h0000_80A5, "R13 clear wins");
    // last pin
    wsel(8'h3E); send(1, 8'h10, 32'h0000_0033); rd(8'h10, 32'h0000_0033, "R4 last pin");
    // R5 out of range
    wsel(8'h40); rd(8'h10, 32'hFFFF_FFFF, "R5 read beyond table");
    send(1, 8'h10, 32'h0);
    chk(entry_wr == 0, "R5 no strobe", 64'(entry_wr), 0);
    wsel(8'hFF); rd(8'h10, 32'hFFFF_FFFF, "R5 top index");
    // R10 unmapped
    wsel(8'h0F); rd(8'h10, 32'h0, "R10 reserved select");
    rd(8'h04, 32'h0, "R10 offset 0x04");
    rd(8'h20, 32'h0, "R10 offset 0x20");
    send(1, 8'h08, 32'h0000_0055); rd(8'h00, 32'h0F, "R10 write elsewhere ignored");
    // R11 back-pressure
    @(negedge clk); rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 8'h00;
    @(posedge clk); @(negedge clk); req_valid = 0;
    repeat (3) begin
      chk(rsp_valid && rsp_rdata == 32'h0F && !req_ready, "R11 held response",
          64'({rsp_valid, req_ready, rsp_rdata}), 64'({2'b10, 32'h0F}));
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid, "R11 drained", 64'(rsp_valid), 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule